// File: doc/BRIEF.md
# Eight-Way Sliced CRC-32 Datapath

This block folds one 64-bit data word per clock into a running reflected CRC-32 remainder (polynomial 0xEDB88320 in bit-reversed form). The word is split into eight bytes, and each byte selects an entry from its own 256-entry remainder table. The tables are built by a constant function at elaboration, so no memory image is needed. The new remainder is the XOR of the eight table outputs.

Only the low four bytes of the word are combined with the running remainder. The high four bytes index their tables straight from the input, so those four lookups and their XOR are registered one stage ahead. The remainder feedback loop then holds four lookups and one XOR level. A message is a whole number of words. The first word carries an init flag that restarts from the all-ones seed, and the last word carries a last flag that marks the finished CRC.

Top module: `crc_s8_top`

## Requirements
- R1: While reset is asserted and on the first clock after release, state_o is 0xFFFFFFFF and done_o is 0.
- R2: crc_o is always the bitwise inverse of state_o.
- R3: A word presented with valid_i high updates state_o exactly two rising edges later. The new value equals a bit-serial reflected CRC-32 (polynomial 0xEDB88320) of the previous state over the 64 data bits. Bits are taken LSB first: data_i[0] first and data_i[63] last.
- R4: A cycle with valid_i and init_i both low leaves state_o unchanged.
- R5: init_i high with valid_i low loads state_o with 0xFFFFFFFF two edges later.
- R6: init_i high together with valid_i high folds the word into the all-ones seed, and the prior state has no effect.
- R7: done_o is high for exactly the cycles in which state_o holds the result of a word that was presented with valid_i and last_i both high. last_i without valid_i raises nothing.
- R8: Words can be accepted on every clock with no gap, including init and last words back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart from the all-ones seed |
| valid_i | input | 1 | data_i holds a word to fold |
| last_i | input | 1 | Word is the final one of a message |
| data_i | input | 64 | Data word, byte 0 in bits 7:0 is first |
| state_o | output | 32 | Running remainder |
| crc_o | output | 32 | Inverted remainder, the finished CRC |
| done_o | output | 1 | state_o holds the result of a last word |

## Verification
The bench builds the block with its default polynomial and seed, so the eight tables hold the full reflected CRC-32 slicing and every reference value comes from a plain bit-by-bit loop in the bench. Random word streams drive all byte lanes through all four data-dependent and all four state-dependent tables. Random mixes of init, last and idle cycles reach the cases where the seed replaces a dirty state while a word is already in the early stage.

// File: rtl/crc_s8_pkg.sv
package crc_s8_pkg;
  localparam int unsigned CRC_W   = 32;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_LANE  = DATA_W / BYTE_W;
  localparam int unsigned HALF_N  = N_LANE / 2;
  localparam int unsigned TBL_D   = 1 << BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef crc_t tbl_t [TBL_D];

  // Entry n of slice k: byte n pushed through 8*(k+1) zero-input steps.
  function automatic tbl_t lut_build(int unsigned slice, crc_t poly);
    tbl_t t;
    crc_t c;
    for (int n = 0; n < TBL_D; n++) begin
      c = crc_t'(n);
      for (int b = 0; b < BYTE_W * (slice + 1); b++)
        c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
      t[n] = c;
    end
    return t;
  endfunction
endpackage

// File: rtl/crc_s8_lut.sv
module crc_s8_lut
  import crc_s8_pkg::*;
#(
  parameter int unsigned SLICE = 0,
  parameter crc_t        POLY  = 32'hEDB88320
) (
  input  byte_t idx_i,
  output crc_t  val_o
);
  localparam tbl_t TBL = lut_build(SLICE, POLY);
  assign val_o = TBL[idx_i];
endmodule

// File: rtl/crc_s8_pre.sv
module crc_s8_pre
  import crc_s8_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HALF_N*BYTE_W-1:0] hi_i,
  output crc_t                    pre_q_o
);
  crc_t lane_val [HALF_N];
  crc_t pre_d;

  // Lanes HALF_N..N_LANE-1 never see the remainder.
  for (genvar g = 0; g < HALF_N; g++) begin : g_lane
    crc_s8_lut #(.SLICE(HALF_N - 1 - g), .POLY(POLY)) i_lut (
      .idx_i(hi_i[g*BYTE_W +: BYTE_W]),
      .val_o(lane_val[g])
    );
  end

  always_comb begin
    pre_d = '0;
    for (int g = 0; g < HALF_N; g++) pre_d ^= lane_val[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q_o <= '0;
    else         pre_q_o <= pre_d;
  end
endmodule

// File: rtl/crc_s8_fold.sv
module crc_s8_fold
  import crc_s8_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320
) (
  input  crc_t mix_i,
  input  crc_t pre_i,
  output crc_t nxt_o
);
  crc_t lane_val [HALF_N];

  for (genvar g = 0; g < HALF_N; g++) begin : g_lane
    crc_s8_lut #(.SLICE(N_LANE - 1 - g), .POLY(POLY)) i_lut (
      .idx_i(mix_i[g*BYTE_W +: BYTE_W]),
      .val_o(lane_val[g])
    );
  end

  always_comb begin
    nxt_o = pre_i;
    for (int g = 0; g < HALF_N; g++) nxt_o ^= lane_val[g];
  end
endmodule

// File: rtl/crc_s8_top.sv
module crc_s8_top
  import crc_s8_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320,
  parameter crc_t SEED = 32'hFFFFFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  state_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  localparam int unsigned LO_W = HALF_N * BYTE_W;

  logic    s1_vld, s1_init, s1_last;
  crc_t    s1_lo;
  crc_t    pre_q;
  crc_t    state_q;
  crc_t    mix;
  crc_t    nxt;
  logic    done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_init <= 1'b0;
      s1_last <= 1'b0;
      s1_lo   <= '0;
    end else begin
      s1_vld  <= valid_i;
      s1_init <= init_i;
      s1_last <= last_i;
      s1_lo   <= data_i[LO_W-1:0];
    end
  end

  crc_s8_pre #(.POLY(POLY)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hi_i   (data_i[DATA_W-1:LO_W]),
    .pre_q_o(pre_q)
  );

  // Seed replaces the state in the same cycle an init word folds in.
  assign mix = (s1_init ? SEED : state_q) ^ s1_lo;

  crc_s8_fold #(.POLY(POLY)) i_fold (
    .mix_i(mix),
    .pre_i(pre_q),
    .nxt_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      done_q  <= 1'b0;
    end else begin
      if (s1_vld)       state_q <= nxt;
      else if (s1_init) state_q <= SEED;
      done_q <= s1_vld & s1_last;
    end
  end

  assign state_o = state_q;
  assign crc_o   = ~state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/crc_s8_chk.sv
module crc_s8_chk
  import crc_s8_pkg::*;
#(
  parameter crc_t SEED = 32'hFFFFFFFF
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic last_i,
  input logic s1_vld,
  input logic s1_init,
  input crc_t state_o,
  input logic done_o
);
  a_r1_reset_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (state_o == SEED && !done_o));

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_vld && !s1_init) |=> $stable(state_o));

  a_r5_seed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_vld && s1_init) |=> (state_o == SEED));

  a_r7_done_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i, 2));
endmodule

bind crc_s8_top crc_s8_chk #(.SEED(SEED)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .last_i (last_i),
  .s1_vld (s1_vld),
  .s1_init(s1_init),
  .state_o(state_o),
  .done_o (done_o)
);

// File: tb/test_crc_s8_top.sv
module test_crc_s8_top;
  localparam int CLK_T = 10;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [31:0] SEED = 32'hFFFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0, valid = 1'b0, last = 1'b0;
  logic [63:0] data = '0;
  logic [31:0] state, crc;
  logic        done;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] model = SEED;
  logic [31:0] h0 = SEED, h1 = SEED;
  logic        d0 = 0, d1 = 0;
  string       t0 = "R1", t1 = "R1";

  always #(CLK_T/2) clk = ~clk;

  crc_s8_top i_crc_s8_top (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .valid_i(valid),
    .last_i(last), .data_i(data), .state_o(state), .crc_o(crc), .done_o(done)
  );

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [63:0] w);
    for (int i = 0; i < 64; i++) begin
      logic b;
      b = c[0] ^ w[i];
      c = c >> 1;
      if (b) c ^= POLY;
    end
    return c;
  endfunction

  task automatic check_out(string tag, logic [31:0] es, logic ed);
    bit bad = 0;
    n_vec++;
    if (state !== es) begin
      $display("FAIL %s state_o act=%h exp=%h", tag, state, es); bad = 1;
    end
    if (crc !== ~es) begin
      $display("FAIL R2 crc_o act=%h exp=%h", crc, ~es); bad = 1;
    end
    if (done !== ed) begin
      $display("FAIL %s done_o act=%b exp=%b", (tag == "R1") ? "R1" : "R7", done, ed); bad = 1;
    end
    if (bad) n_bad++;
  endtask

  task automatic step(logic v, logic ini, logic lst, logic [63:0] w, string tag);
    @(negedge clk);
    check_out(t1, h1, d1);
    h1 = h0; d1 = d0; t1 = t0;
    if (v) model = ref_crc(ini ? SEED : model, w);
    else if (ini) model = SEED;
    h0 = model; d0 = v & lst; t0 = tag;
    valid = v; init = ini; last = lst; data = w;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_out("R1", SEED, 1'b0);          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", SEED, 1'b0);          // R1 after release
    step(0, 1, 0, '0, "R5");
    for (int k = 0; k < 20; k++) begin    // R3 isolated words
      step(1, 0, 0, rnd64(), "R3");
      step(0, 0, 0, rnd64(), "R4");
    end
    step(1, 1, 0, 64'h0, "R3");           // R3 zero word from seed
    step(1, 1, 0, '1, "R3");              // R3 all-ones word from seed
    for (int k = 0; k < 5; k++) step(0, 0, 1, rnd64(), "R4");
    step(1, 0, 0, rnd64(), "R5");
    step(0, 1, 0, rnd64(), "R5");         // R5 seed reload
    step(0, 0, 0, '0, "R5");
    for (int k = 0; k < 10; k++) begin    // R6 init word ignores dirty state
      step(1, 0, 0, rnd64(), "R6");
      step(1, 1, 0, rnd64(), "R6");
    end
    for (int k = 0; k < 30; k++) begin    // R7 messages back to back
      int len = 1 + ($urandom % 4);
      for (int j = 0; j < len; j++)
        step(1, j == 0, j == len - 1, rnd64(), "R7");
    end
    for (int k = 0; k < 2000; k++) begin  // R8 random stream
      int r = $urandom % 100;
      step(r < 75, ($urandom % 10) == 0, ($urandom % 5) == 0, rnd64(), "R8");
    end
    for (int k = 0; k < 3; k++) step(0, 0, 0, '0, "R4");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule